// File: doc/BRIEF.md
# Six-Address Nonvolatile Command Detector

This block sits beside the access path of a battery-backed static RAM. It watches the stream of chip-enable access cycles and looks for a fixed series of six read addresses. The series is the same for both commands up to the fifth step. The sixth address then chooses the command. One value asks the cycle controller to copy the RAM into its nonvolatile shadow. The other asks it to copy the shadow back into the RAM. The block reports a match as a single-cycle request pulse to that controller.

Each access arrives as a one-cycle synchronous strobe, which marks the falling edge of chip-enable. The 13-bit address and the write-enable level are captured with that strobe. Output-enable plays no part in recognition, so it is not an input. Progress is lost in any of these cases:
- any access that is not the next expected read;
- any write;
- a repeated strobe on an unchanged address, which is taken as a double clock.

While the controller reports a nonvolatile cycle in progress, the detector forgets its progress and disregards strobes.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: Six consecutive read strobes (write-enable high, `acc_we_n`=1) at addresses 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F, in that order, make `store_req` high for exactly the one clock cycle that follows the sixth strobe.
- R2: The same five leading reads followed by a read of 0x0F0E make `recall_req` high for exactly the one clock cycle that follows the sixth strobe.
- R3: A strobe with `acc_we_n`=0 at any point aborts the sequence, even when its address is the expected one. No request results until a fresh series starting at 0x0000 completes.
- R4: A read strobe whose address is not the expected next one aborts the sequence. If that address is 0x0000, it is counted as the first step of a new series. A sixth address other than the two command values produces no request.
- R5: A strobe whose address equals the address of the immediately preceding accepted strobe is a double clock. It aborts the sequence and counts as no step.
- R6: Changes of `acc_addr` or `acc_we_n` without `acc_strobe` have no effect on progress. Idle cycles between steps are allowed.
- R7: While `nv_busy` is high, progress and double-clock history are cleared, and strobes are ignored and produce no request.
- R8: After reset both request outputs are low. The two requests are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_strobe | input | 1 | One-cycle pulse per chip-enable falling edge |
| acc_addr | input | 13 | Access address captured with the strobe |
| acc_we_n | input | 1 | Write-enable level at the strobe (0 = write) |
| nv_busy | input | 1 | Controller reports a nonvolatile cycle in progress |
| store_req | output | 1 | One-cycle request to copy RAM into nonvolatile storage |
| recall_req | output | 1 | One-cycle request to copy nonvolatile storage into RAM |

## Verification
The hardest situation to reach from the ports is a series that nearly matches. This covers three cases:
- a restart from 0x0000 in the middle of the series, which must still complete;
- a double clock on a correct step address, which must not complete;
- a busy window that begins after five good steps and must wipe them.

The stimulus builds each of these from the valid series with one strobe altered, inserted or repeated. It then follows with the remaining valid steps, so that any leftover progress would show up as a request pulse. Each strobe queues its expected request pair for the monitor, which compares it one cycle later.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
  localparam int ADDR_W    = 13;
  localparam int SEQ_LEN   = 6;
  localparam int LEAD_LEN  = SEQ_LEN - 1;
  localparam int STEP_W    = $clog2(SEQ_LEN);
  localparam int LAST_STEP = SEQ_LEN - 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam addr_t STORE_KEY  = 13'h0F0F;
  localparam addr_t RECALL_KEY = 13'h0F0E;

  typedef enum logic [1:0] {CMD_NONE, CMD_STORE, CMD_RECALL} cmd_e;

  // Address expected at each leading step (shared by both commands)
  function automatic addr_t lead_addr(input int idx);
    case (idx)
      0:       return 13'h0000;
      1:       return 13'h1555;
      2:       return 13'h0AAA;
      3:       return 13'h1FFF;
      4:       return 13'h10F0;
      default: return '0;
    endcase
  endfunction

  function automatic step_t step_of(input int idx);
    return step_t'(idx);
  endfunction
endpackage

// File: rtl/nvcmd_addr_match.sv
module nvcmd_addr_match
  import nvcmd_pkg::*;
(
  input  step_t step,
  input  addr_t addr,
  output logic  hit,
  output logic  restart_hit,
  output cmd_e  cmd
);
  logic [LEAD_LEN-1:0] lead_hit;

  for (genvar i = 0; i < LEAD_LEN; i++) begin : g_lead
    assign lead_hit[i] = (addr == lead_addr(i));
  end

  assign restart_hit = lead_hit[0];

  always_comb begin
    hit = 1'b0;
    cmd = CMD_NONE;
    if (step == step_of(LAST_STEP)) begin
      if (addr == STORE_KEY)       cmd = CMD_STORE;
      else if (addr == RECALL_KEY) cmd = CMD_RECALL;
      hit = (cmd != CMD_NONE);
    end else begin
      for (int i = 0; i < LEAD_LEN; i++)
        if (step == step_of(i)) hit = lead_hit[i];
    end
  end
endmodule

// File: rtl/nvcmd_dbl_detect.sv
module nvcmd_dbl_detect
  import nvcmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  take,
  input  addr_t addr,
  output logic  dbl
);
  addr_t prev_addr;
  logic  prev_vld;

  assign dbl = take && prev_vld && (addr == prev_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_vld  <= 1'b0;
    end else if (clr) begin
      prev_vld  <= 1'b0;
    end else if (take) begin
      prev_addr <= addr;
      prev_vld  <= 1'b1;
    end
  end
endmodule

// File: rtl/nvcmd_step_fsm.sv
module nvcmd_step_fsm
  import nvcmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  take,
  input  logic  we_n,
  input  logic  dbl,
  input  logic  hit,
  input  logic  restart_hit,
  input  cmd_e  cmd,
  output step_t step,
  output logic  store_req,
  output logic  recall_req
);
  step_t step_nx;
  logic  abort;
  logic  fire_store, fire_recall;

  assign abort       = dbl || !we_n;
  assign fire_store  = take && !abort && (cmd == CMD_STORE);
  assign fire_recall = take && !abort && (cmd == CMD_RECALL);

  always_comb begin
    step_nx = step;
    if (clr)                         step_nx = '0;
    else if (take) begin
      if (abort)                     step_nx = '0;
      else if (hit)                  step_nx = (step == step_of(LAST_STEP)) ? '0 : step + 1'b1;
      else if (restart_hit)          step_nx = step_of(1);
      else                           step_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      step       <= step_nx;
      store_req  <= fire_store;
      recall_req <= fire_recall;
    end
  end
endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
  import nvcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_strobe,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_we_n,
  input  logic              nv_busy,
  output logic              store_req,
  output logic              recall_req
);
  logic  take;
  logic  dbl_hit;
  logic  step_hit, restart_hit;
  cmd_e  cmd_sel;
  step_t step_q;

  assign take = acc_strobe && !nv_busy;

  nvcmd_dbl_detect u_dbl (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (nv_busy),
    .take  (take),
    .addr  (acc_addr),
    .dbl   (dbl_hit)
  );

  nvcmd_addr_match u_match (
    .step        (step_q),
    .addr        (acc_addr),
    .hit         (step_hit),
    .restart_hit (restart_hit),
    .cmd         (cmd_sel)
  );

  nvcmd_step_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (nv_busy),
    .take        (take),
    .we_n        (acc_we_n),
    .dbl         (dbl_hit),
    .hit         (step_hit),
    .restart_hit (restart_hit),
    .cmd         (cmd_sel),
    .step        (step_q),
    .store_req   (store_req),
    .recall_req  (recall_req)
  );
endmodule

// File: rtl/nvcmd_seq_chk.sv
module nvcmd_seq_chk
  import nvcmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_strobe,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_we_n,
  input logic              nv_busy,
  input logic              store_req,
  input logic              recall_req,
  input logic              dbl_hit,
  input step_t             step_q
);
  p_store_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(acc_strobe && acc_we_n && !nv_busy &&
                        acc_addr == STORE_KEY && step_q == step_of(LAST_STEP)));

  p_recall_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> $past(acc_strobe && acc_we_n && !nv_busy &&
                         acc_addr == RECALL_KEY && step_q == step_of(LAST_STEP)));

  p_write_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && !acc_we_n) |=> (!store_req && !recall_req));

  p_write_resets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && !acc_we_n) |=> (step_q == '0));

  p_dbl_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_hit |=> (!store_req && !recall_req && step_q == '0));

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> (!store_req && !recall_req && step_q == '0));

  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_strobe && !nv_busy) |=> $stable(step_q));

  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_req, recall_req}));

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |=> (!store_req && !recall_req));
endmodule

bind nvcmd_seq_detect nvcmd_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_strobe (acc_strobe),
  .acc_addr   (acc_addr),
  .acc_we_n   (acc_we_n),
  .nv_busy    (nv_busy),
  .store_req  (store_req),
  .recall_req (recall_req),
  .dbl_hit    (dbl_hit),
  .step_q     (step_q)
);

// File: tb/tb_nvcmd_seq_detect.sv
module tb_nvcmd_seq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_strobe = 1'b0;
  logic [12:0] acc_addr = '0;
  logic        acc_we_n = 1'b1;
  logic        nv_busy = 1'b0;
  logic        store_req, recall_req;

  int checks = 0;
  int failures = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];   // {store, recall}
  string      tag_q[$];

  localparam logic [1:0] NONE = 2'b00, ST = 2'b10, RC = 2'b01;

  always #5 clk = ~clk;

  nvcmd_seq_detect dut (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
    .acc_we_n(acc_we_n), .nv_busy(nv_busy), .store_req(store_req), .recall_req(recall_req)
  );

  // Monitor: compares each queued expectation one cycle after its strobe
  always @(negedge clk) begin
    if (running) begin
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({store_req, recall_req} !== e) begin
          failures++;
          $display("FAIL %s: got {store,recall}=%b expected %b", t, {store_req, recall_req}, e);
        end
      end else if (store_req || recall_req) begin
        checks++;
        failures++;
        $display("FAIL R8: stray request {store,recall}=%b expected 00", {store_req, recall_req});
      end
    end
  end

  task automatic send(input logic [12:0] a, input logic we, input logic [1:0] e, input string t);
    @(negedge clk);
    acc_addr = a; acc_we_n = we; acc_strobe = 1'b1;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    #1 acc_strobe = 1'b0;
  endtask

  task automatic lead(input string t);
    send(13'h0000, 1'b1, NONE, t);
    send(13'h1555, 1'b1, NONE, t);
    send(13'h0AAA, 1'b1, NONE, t);
    send(13'h1FFF, 1'b1, NONE, t);
    send(13'h10F0, 1'b1, NONE, t);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    done = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (store_req !== 1'b0 || recall_req !== 1'b0) begin
      failures++;
      $display("FAIL R8: reset outputs %b expected 00", {store_req, recall_req});
    end
    rst_n = 1'b1;
    idle(2);
    running = 1'b1;

    // R1: plain store series
    lead("R1");
    send(13'h0F0F, 1'b1, ST, "R1 store");
    idle(3);

    // R2: recall series, back to back
    lead("R2");
    send(13'h0F0E, 1'b1, RC, "R2 recall");
    idle(3);

    // R3: write at an expected address aborts
    send(13'h0000, 1'b1, NONE, "R3");
    send(13'h1555, 1'b1, NONE, "R3");
    send(13'h0AAA, 1'b0, NONE, "R3 write");
    send(13'h1FFF, 1'b1, NONE, "R3");
    send(13'h10F0, 1'b1, NONE, "R3");
    send(13'h0F0F, 1'b1, NONE, "R3 no store after write");
    idle(2);
    lead("R3");
    send(13'h0F0F, 1'b1, ST, "R3 fresh series works");
    idle(2);

    // R4: foreign read aborts
    send(13'h0000, 1'b1, NONE, "R4");
    send(13'h1555, 1'b1, NONE, "R4");
    send(13'h0123, 1'b1, NONE, "R4 foreign");
    send(13'h1FFF, 1'b1, NONE, "R4");
    send(13'h10F0, 1'b1, NONE, "R4");
    send(13'h0F0F, 1'b1, NONE, "R4 no store after foreign");
    idle(2);
    // R4: 0000 mid-series restarts as step one
    send(13'h0000, 1'b1, NONE, "R4");
    send(13'h1555, 1'b1, NONE, "R4");
    lead("R4 restart");
    send(13'h0F0E, 1'b1, RC, "R4 recall after restart");
    idle(2);
    // R4: wrong sixth address
    lead("R4");
    send(13'h0F0D, 1'b1, NONE, "R4 bad sixth");
    send(13'h0F0F, 1'b1, NONE, "R4 store key alone");
    idle(2);

    // R5: double clock on a correct address
    send(13'h0000, 1'b1, NONE, "R5");
    send(13'h1555, 1'b1, NONE, "R5");
    send(13'h1555, 1'b1, NONE, "R5 double");
    send(13'h0AAA, 1'b1, NONE, "R5");
    send(13'h1FFF, 1'b1, NONE, "R5");
    send(13'h10F0, 1'b1, NONE, "R5");
    send(13'h0F0F, 1'b1, NONE, "R5 no store after double");
    idle(2);
    send(13'h0000, 1'b1, NONE, "R5");
    send(13'h0000, 1'b1, NONE, "R5 double first");
    send(13'h1555, 1'b1, NONE, "R5");
    send(13'h0AAA, 1'b1, NONE, "R5");
    send(13'h1FFF, 1'b1, NONE, "R5");
    send(13'h10F0, 1'b1, NONE, "R5");
    send(13'h0F0F, 1'b1, NONE, "R5 no store after first double");
    idle(2);

    // R6: bus activity without strobe between steps
    send(13'h0000, 1'b1, NONE, "R6");
    @(negedge clk); acc_addr = 13'h0333; acc_we_n = 1'b0;
    @(negedge clk); acc_addr = 13'h1555; acc_we_n = 1'b0;
    send(13'h1555, 1'b1, NONE, "R6");
    send(13'h0AAA, 1'b1, NONE, "R6");
    @(negedge clk); acc_addr = 13'h0000; acc_we_n = 1'b0;
    idle(3);
    send(13'h1FFF, 1'b1, NONE, "R6");
    send(13'h10F0, 1'b1, NONE, "R6");
    send(13'h0F0F, 1'b1, ST, "R6 store with idle gaps");
    idle(2);

    // R7: busy window after five steps wipes progress
    lead("R7");
    @(negedge clk); nv_busy = 1'b1;
    idle(2);
    @(negedge clk); nv_busy = 1'b0;
    send(13'h0F0F, 1'b1, NONE, "R7 progress cleared");
    idle(2);
    // R7: sixth strobe during busy is ignored
    lead("R7");
    @(negedge clk); nv_busy = 1'b1;
    send(13'h0F0E, 1'b1, NONE, "R7 strobe while busy");
    @(negedge clk); nv_busy = 1'b0;
    send(13'h0F0E, 1'b1, NONE, "R7 after busy");
    idle(2);
    // R7: whole series under busy produces nothing, then a clean one works
    @(negedge clk); nv_busy = 1'b1;
    lead("R7 busy");
    send(13'h0F0F, 1'b1, NONE, "R7 busy series");
    @(negedge clk); nv_busy = 1'b0;
    lead("R7");
    send(13'h0F0F, 1'b1, ST, "R7 clean after busy");
    idle(3);

    running = 1'b0;
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule